// File: doc/BRIEF.md
# Platform-Level Interrupt Controller

This block gathers a set of interrupt request lines, numbered from 1 upward, and presents them to a small number of hart contexts. Every source has a 3-bit priority. Every context has its own enable bitmap, a priority threshold and a claim/complete register. A gateway for each source turns a request into a pending bit. It then stays closed from the moment the source is claimed until software writes its ID back as a completion, so a source is never serviced twice at once.

Each context gets one interrupt line. The line is high while at least one source is pending, is enabled for that context and has a priority strictly above that context's threshold. Software reads the claim register to learn which source to service. That read also moves the source from pending to in-service. Writing the same ID back to the register reopens the gateway. Sources numbered at or above the `EDGE_FIRST` parameter are rising-edge triggered. Lower-numbered sources are level-high triggered.

The register port takes 32-bit words. The address is a byte address whose two low bits are ignored. Read data is combinational and valid in the cycle `bus_re` is high. A claim takes effect at the clock edge that ends that cycle.

Top module: `plat_irq_ctrl`

## Requirements
- R1: After reset all priorities, enable bits, thresholds and pending bits are zero, every `irq_out` bit is low, and every claim read returns 0.
- R2: The priority of source n (1..NSRC) is read and written at byte offset 4*n and holds 3 bits, so only bits [2:0] of a write are kept. Offset 0 (source 0) and offsets of sources above NSRC read 0 and ignore writes.
- R3: The enable bit of source n for context c is bit (n mod 32) of the word at 0x2000 + c*0x80 + 4*(n/32). Bit 0 of word 0 (source 0) always reads 0.
- R4: The threshold of context c is at 0x200000 + c*0x1000 and holds 3 bits. The claim/complete register of context c is at that base + 4.
- R5: A source counts for a context only when it is pending, enabled there and its priority is strictly greater than the threshold. `irq_out[c]` is high exactly when such a source exists. Priority 0 never interrupts, and a threshold of 7 masks everything.
- R6: A claim read returns the counting source with the highest priority, with ties going to the lowest ID, or 0 when none counts. A nonzero claim clears that source's pending bit.
- R7: A level source (ID below EDGE_FIRST, default 16) becomes pending while its request is high and it is not in service. After a claim it cannot pend again until completed. A completion with the request still high makes it pending at once.
- R8: An edge source (ID at or above EDGE_FIRST) becomes pending on a rising edge of its request. Edges during service, including one in the claim cycle itself, are held in a single bit and become one pending request at completion. Further edges are dropped.
- R9: Writing an in-service ID to a claim register completes it even if the source is disabled for that context. A completion with ID 0 or with an ID not in service changes nothing.
- R10: Reads of unimplemented offsets return 0 and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NSRC | Request lines, bit n is source n (bits NSRC..1) |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe; a claim read has a side effect |
| bus_rdata | output | 32 | Read data for the current address |
| irq_out | output | NCTX | Interrupt line for each context |

## Verification
Two gateway events can land on the same clock edge. The first is a rising edge on an edge source in the cycle its claim read is on the bus. The bench raises that request in the same cycle as the read strobe. It then expects one claim read of 0 before completion and the same ID again after completion. The second is a completion arriving while a level request is still high. There the bench expects the source to be claimable again in the very next cycle, which also shows the gateway did not lose the request.

// File: rtl/plat_irq_ctrl.sv
module plat_irq_ctrl #(
  parameter int NSRC       = 31,
  parameter int NCTX       = 2,
  parameter int PW         = 3,
  parameter int EDGE_FIRST = 16,
  parameter int ADDR_W     = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata,
  output logic [NCTX-1:0]   irq_out
);

  localparam int IDW = $clog2(NSRC + 1);
  localparam int NWORD = (NSRC + 32) / 32;
  localparam logic [PW-1:0] PMAX = '1;
  localparam int unsigned EN_BASE = 32'h2000;
  localparam int unsigned EN_STEP = 32'h80;
  localparam int unsigned CX_BASE = 32'h200000;
  localparam int unsigned CX_STEP = 32'h1000;

  logic [PW-1:0]  prio [1:NSRC];
  logic [NSRC:1]  en   [NCTX];
  logic [PW-1:0]  thr  [NCTX];
  logic [IDW-1:0] best [NCTX];
  logic [NSRC:1]  pend, busy;

  int unsigned a, idx, ctx, word;
  logic sel_pri, sel_en, sel_thr, sel_clm;

  always_comb begin
    a = 32'(bus_addr) & ~32'h3;
    idx = 0; ctx = 0; word = 0;
    sel_pri = 1'b0; sel_en = 1'b0; sel_thr = 1'b0; sel_clm = 1'b0;
    if (a < EN_BASE) begin
      idx = a >> 2;
      sel_pri = (idx >= 1) && (idx <= NSRC);
    end else if (a < CX_BASE) begin
      if ((a - EN_BASE) / EN_STEP < NCTX && ((a - EN_BASE) % EN_STEP) / 4 < NWORD) begin
        ctx = (a - EN_BASE) / EN_STEP;
        word = ((a - EN_BASE) % EN_STEP) / 4;
        sel_en = 1'b1;
      end
    end else if ((a - CX_BASE) / CX_STEP < NCTX) begin
      ctx = (a - CX_BASE) / CX_STEP;
      sel_thr = ((a - CX_BASE) % CX_STEP) == 0;
      sel_clm = ((a - CX_BASE) % CX_STEP) == 4;
    end
  end

  logic [31:0] en_word;
  int s;
  always_comb begin
    en_word = '0;
    for (int b = 0; b < 32; b++) begin
      s = int'(word) * 32 + b;
      if (s >= 1 && s <= NSRC) en_word[b] = en[ctx][s];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (sel_pri)      bus_rdata = 32'(prio[idx]);
    else if (sel_en)  bus_rdata = en_word;
    else if (sel_thr) bus_rdata = 32'(thr[ctx]);
    else if (sel_clm) bus_rdata = 32'(best[ctx]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= NSRC; i++) prio[i] <= '0;
      for (int c = 0; c < NCTX; c++) begin
        en[c]  <= '0;
        thr[c] <= '0;
      end
    end else if (bus_we) begin
      if (sel_pri) prio[idx] <= bus_wdata[PW-1:0];
      if (sel_thr) thr[ctx] <= bus_wdata[PW-1:0];
      if (sel_en)
        for (int b = 0; b < 32; b++)
          if (int'(word) * 32 + b >= 1 && int'(word) * 32 + b <= NSRC)
            en[ctx][int'(word) * 32 + b] <= bus_wdata[b];
    end
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_arb
    logic [PW-1:0]  bp;
    logic [IDW-1:0] win;
    always_comb begin
      bp = thr[c];
      win = '0;
      for (int k = 1; k <= NSRC; k++)
        if (pend[k] && en[c][k] && prio[k] > bp) begin
          bp = prio[k];
          win = IDW'(k);
        end
    end
    assign best[c] = win;
    assign irq_out[c] = |win;

    assert_full_threshold_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr[c] == PMAX) |-> !irq_out[c]);
  end

  logic [IDW-1:0] take_id, done_id;
  logic           done_ok;
  always_comb begin
    take_id = (bus_re && sel_clm) ? best[ctx] : '0;
    done_id = IDW'(bus_wdata);
    done_ok = 1'b0;
    if (bus_we && sel_clm && bus_wdata >= 1 && bus_wdata <= NSRC) done_ok = busy[done_id];
  end

  for (genvar i = 1; i <= NSRC; i++) begin : g_gw
    logic take, rel, p_q, b_q;
    assign take = (take_id == IDW'(i));
    assign rel  = done_ok && (done_id == IDW'(i));
    assign pend[i] = p_q;
    assign busy[i] = b_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    b_q <= 1'b0;
      else if (take) b_q <= 1'b1;
      else if (rel)  b_q <= 1'b0;
    end

    if (i >= EDGE_FIRST) begin : g_edge
      logic h_q, d_q, rise;
      assign rise = src_req[i] & ~d_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          p_q <= 1'b0; h_q <= 1'b0; d_q <= 1'b0;
        end else begin
          d_q <= src_req[i];
          if (take) begin
            p_q <= 1'b0;
            h_q <= rise;
          end else if (rel) begin
            p_q <= h_q | rise;
            h_q <= 1'b0;
          end else if (b_q) begin
            if (rise) h_q <= 1'b1;
          end else if (rise) begin
            p_q <= 1'b1;
          end
        end
      end

      assert_held_only_in_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
        h_q |-> b_q);
    end else begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 p_q <= 1'b0;
        else if (take)                              p_q <= 1'b0;
        else if ((rel || !b_q) && src_req[i])       p_q <= 1'b1;
      end
    end

    assert_claim_moves_to_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> (b_q && !p_q));
    assert_no_pend_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(p_q && b_q));
    assert_service_ends_by_completion_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(b_q) |-> $past(rel));
  end

endmodule

// File: tb/plat_irq_ctrl_test.sv
module plat_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:1] src_req = '0;
  logic [21:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq_out;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  plat_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  localparam logic [31:0] CLM0 = 32'h200004;
  localparam logic [31:0] CLM1 = 32'h201004;
  localparam logic [31:0] THR0 = 32'h200000;
  localparam logic [31:0] EN0  = 32'h2000;
  localparam logic [31:0] EN1  = 32'h2080;

  // {requirement number, address, write data, expected read-back}
  localparam logic [103:0] VEC [13] = '{
    {8'd2,  32'h004,    32'h5,        32'h5},        // R2
    {8'd2,  32'h07C,    32'hFF,       32'h7},        // R2
    {8'd2,  32'h000,    32'h7,        32'h0},        // R2
    {8'd10, 32'h080,    32'h3,        32'h0},        // R10
    {8'd3,  32'h2000,   32'hFFFFFFFF, 32'hFFFFFFFE}, // R3
    {8'd3,  32'h2080,   32'h6,        32'h6},        // R3
    {8'd10, 32'h2004,   32'h1,        32'h0},        // R10
    {8'd10, 32'h2100,   32'h1,        32'h0},        // R10
    {8'd4,  32'h200000, 32'h2,        32'h2},        // R4
    {8'd4,  32'h201000, 32'hF,        32'h7},        // R4
    {8'd10, 32'h200008, 32'h5,        32'h0},        // R10
    {8'd10, 32'h1000,   32'h1,        32'h0},        // R10
    {8'd10, 32'h202000, 32'h3,        32'h0}         // R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_req = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a[21:0]; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a[21:0]; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse(input int n);
    @(negedge clk); src_req[n] = 1'b1;
    @(negedge clk); src_req[n] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    do_reset();

    // R1 reset state
    #1 chk("R1 irq_out", 32'(irq_out), 0);
    rd(CLM0, d); chk("R1 claim ctx0", d, 0);
    rd(CLM1, d); chk("R1 claim ctx1", d, 0);
    rd(32'h4, d); chk("R1 prio", d, 0);
    rd(EN0, d); chk("R1 enable", d, 0);
    rd(THR0, d); chk("R1 threshold", d, 0);

    // Register map table: R2 R3 R4 R10
    for (int v = 0; v < 13; v++) begin
      wr(VEC[v][95:64], VEC[v][63:32]);
      rd(VEC[v][95:64], d);
      chk($sformatf("R%0d map @%0h", VEC[v][103:96], VEC[v][95:64]), d, VEC[v][31:0]);
    end

    // Level sources, arbitration, blocking
    do_reset();
    wr(4*3, 4); wr(4*5, 4);
    wr(EN0, (1<<3)|(1<<5)|(1<<7)|(1<<9)|(1<<10)|(1<<11)|(1<<12));
    @(negedge clk); src_req[3] = 1'b1; src_req[5] = 1'b1;
    @(negedge clk);
    #1 chk("R5 irq ctx0", 32'(irq_out[0]), 1);
    chk("R5 irq ctx1 not enabled", 32'(irq_out[1]), 0);
    rd(CLM0, d); chk("R6 tie lowest id", d, 3);
    rd(CLM0, d); chk("R6 second claim", d, 5);
    rd(CLM0, d); chk("R7 blocked in service", d, 0);
    #1 chk("R7 irq low while blocked", 32'(irq_out[0]), 0);
    src_req[3] = 1'b0;
    wr(CLM0, 3);
    rd(CLM0, d); chk("R7 no repend when low", d, 0);
    wr(CLM0, 5);
    rd(CLM0, d); chk("R7 repend at completion", d, 5);
    src_req[5] = 1'b0;
    wr(CLM0, 5);
    rd(CLM0, d); chk("R7 idle", d, 0);

    // Threshold strictness
    wr(4*7, 6);
    src_req[7] = 1'b1;
    wr(THR0, 6);
    #1 chk("R5 equal to threshold", 32'(irq_out[0]), 0);
    rd(CLM0, d); chk("R5 claim under threshold", d, 0);
    wr(THR0, 5);
    #1 chk("R5 above threshold", 32'(irq_out[0]), 1);
    rd(CLM0, d); chk("R5 claim above threshold", d, 7);
    src_req[9] = 1'b1;
    wr(THR0, 0);
    #1 chk("R5 priority zero", 32'(irq_out[0]), 0);
    src_req[9] = 1'b0;

    // Completion while disabled, bogus completions
    wr(EN0, (1<<3)|(1<<5)|(1<<9)|(1<<10)|(1<<11)|(1<<12));
    wr(CLM0, 7);
    wr(EN0, (1<<3)|(1<<5)|(1<<7)|(1<<9)|(1<<10)|(1<<11)|(1<<12));
    rd(CLM0, d); chk("R9 completion while disabled", d, 7);
    wr(CLM0, 12);
    wr(CLM0, 0);
    rd(CLM0, d); chk("R9 unclaimed completion ignored", d, 0);

    // Higher priority beats lower id
    wr(4*10, 2); wr(4*11, 6);
    @(negedge clk); src_req[10] = 1'b1; src_req[11] = 1'b1;
    rd(CLM0, d); chk("R6 highest priority", d, 11);
    rd(CLM0, d); chk("R6 next priority", d, 10);

    // Edge sources on context 1
    do_reset();
    wr(4*20, 3); wr(4*21, 3);
    wr(EN1, (1<<20)|(1<<21));
    pulse(20);
    #1 chk("R8 edge pends ctx1", 32'(irq_out), 2);
    rd(CLM1, d); chk("R8 claim edge", d, 20);
    pulse(20); pulse(20);
    rd(CLM1, d); chk("R8 held not pending", d, 0);
    wr(CLM1, 20);
    rd(CLM1, d); chk("R8 held becomes pending", d, 20);
    wr(CLM1, 20);
    rd(CLM1, d); chk("R8 extra edges dropped", d, 0);

    // Edge in the same cycle as its claim read
    pulse(21);
    @(negedge clk);
    bus_addr = CLM1[21:0]; bus_re = 1'b1; src_req[21] = 1'b1;
    #1 d = bus_rdata;
    chk("R8 claim with coincident edge", d, 21);
    @(negedge clk);
    bus_re = 1'b0; src_req[21] = 1'b0;
    rd(CLM1, d); chk("R8 coincident edge blocked", d, 0);
    wr(CLM1, 21);
    rd(CLM1, d); chk("R8 coincident edge kept", d, 21);
    wr(CLM1, 21);
    rd(CLM1, d); chk("R8 final idle", d, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule